// File: doc/BRIEF.md
# Password-Gated Configuration Register Bank

This block keeps the run-time settings of a bus-attached supervisor: the node address, the baud selection, the watchdog timeout in seconds and the unlock password. Software reaches it through a plain register port with a write strobe, a 3-bit address and 16-bit data. The currently active settings drive the rest of the supervisor through dedicated outputs. Every change goes first into a shadow copy. The live outputs follow the shadow copy only once the bank has been unlocked and a commit code has been written.

A small state machine has two named states. In **Locked** (encoding 0), only the command register at address 1 responds. Writing the active password there takes the **Unlock** transition to **Staging** (encoding 1). While in Staging, addresses 2, 3 and 4 edit the shadow copy. Writing the commit code 0x5FAF to address 1 takes the **Commit** transition back to Locked, and the whole shadow copy becomes active in one cycle. Writing 0x0000 takes the **Cancel** transition back to Locked and reloads the shadow from the active copy. Any other value written to address 1 while in Staging is a **Hold**, and so is any write in Locked that does not match the password.

Address 2 packs two byte fields: the baud index in bits [15:8] and the node ID in bits [7:0]. Each field is checked on its own. A zero keeps the field as it is, and a value out of range is dropped. Reads return the shadow copy, which equals the active copy whenever the bank is Locked.

Top module: `cfg_bank`

## Requirements
- R1: After reset, node_id is 0xFF, baud_idx is 1, wdt_timeout is 60 and cfg_state is 0. Reads return 0x01FF at address 2, 0x003C at address 3 and 0xDEFA at address 4.
- R2: While Locked, writing the active password (0xDEFA after reset) to address 1 sets cfg_state to 1 on the next cycle. Any other value leaves the state at 0.
- R3: While Locked, writes to addresses 2, 3 and 4 change neither the readback nor the outputs.
- R4: In Staging, a node ID byte (address 2, bits [7:0]) is taken only when it is between 1 and 247 inclusive.
- R5: In Staging, a baud byte (address 2, bits [15:8]) is taken only when it is between 1 and 5 inclusive. A rejected baud byte does not block a valid node ID byte in the same write.
- R6: A zero in either byte of an address 2 write leaves that field unchanged while the other field updates.
- R7: In Staging, writing 0x5FAF to address 1 copies every staged value to node_id, baud_idx and wdt_timeout, and to the password, on the next cycle, and returns cfg_state to 0. The outputs do not change before that.
- R8: In Staging, writing 0x0000 to address 1 returns cfg_state to 0, discards the staged values (the readback shows the active ones again) and leaves the outputs unchanged.
- R9: In Staging, address 3 stages any 16-bit timeout and address 4 stages a new password. A new password equal to 0x5FAF or 0x0000 is rejected. Once committed, only the new password unlocks the bank.
- R10: Reading address 1 returns cfg_state in bit 0 with zeros above it. In Staging, writing to address 1 a value that is neither a command code nor a match keeps the bank in Staging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational readback of the addressed register |
| node_id | output | 8 | Active node address |
| baud_idx | output | 8 | Active baud selection index |
| wdt_timeout | output | 16 | Active watchdog timeout in seconds |
| cfg_state | output | 1 | Configuration state, 0 Locked, 1 Staging |

## Verification
The bench goes after the field-validation edges: node IDs 247 and 248, baud 5 and 6, zero bytes, and mixed writes where one byte is valid and the other is not. A design that validated the whole word as one unit would drop the good byte, and one that treated zero as a value would wipe a field. It checks that the outputs hold still during staging until the commit cycle, and that a cancel restores the readback; a design that wrote through to the outputs, or forgot the shadow reload, would show stale or early values there. It also tries command codes as passwords and the old password after a change, which catches a design that compares against the staged password or lets a command value become the key.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

    typedef enum logic {
        CFG_LOCKED  = 1'b0,
        CFG_STAGING = 1'b1
    } cfg_state_e;

    typedef struct packed {
        logic [15:0] pw;
        logic [15:0] tmo;
        logic [7:0]  baud;
        logic [7:0]  node;
    } cfg_rec_t;

    localparam int unsigned REG_STATUS = 0;
    localparam int unsigned REG_CMD    = 1;
    localparam int unsigned REG_LINK   = 2;
    localparam int unsigned REG_TMO    = 3;
    localparam int unsigned REG_PW     = 4;

    localparam logic [15:0] CODE_APPLY   = 16'h5FAF;
    localparam logic [15:0] CODE_DISCARD = 16'h0000;

endpackage

// File: rtl/cfg_byte_gate.sv
module cfg_byte_gate #(
    parameter int unsigned LO = 1,
    parameter int unsigned HI = 255
) (
    input  logic [7:0] cur_i,
    input  logic [7:0] req_i,
    output logic [7:0] nxt_o
);
    localparam logic [7:0] LO_B = LO[7:0];
    localparam logic [7:0] HI_B = HI[7:0];

    logic take;

    always_comb begin
        take  = (req_i != 8'd0) && (req_i >= LO_B) && (req_i <= HI_B);
        nxt_o = take ? req_i : cur_i;
    end

endmodule

// File: rtl/cfg_bank_fsm.sv
module cfg_bank_fsm
    import cfg_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic [15:0]       key_i,
    output cfg_state_e        state_o,
    output logic              stage_en_o,
    output logic              apply_o,
    output logic              discard_o
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(REG_CMD);

    cfg_state_e state_q, state_d;
    logic       cmd_wr;

    assign cmd_wr = wr_en && (addr == A_CMD);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CFG_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        apply_o    = 1'b0;
        discard_o  = 1'b0;
        stage_en_o = 1'b0;
        unique case (state_q)
            CFG_LOCKED: begin
                if (cmd_wr && (wdata == key_i)) state_d = CFG_STAGING;
            end
            CFG_STAGING: begin
                stage_en_o = 1'b1;
                if (cmd_wr && (wdata == CODE_APPLY)) begin
                    apply_o = 1'b1;
                    state_d = CFG_LOCKED;
                end else if (cmd_wr && (wdata == CODE_DISCARD)) begin
                    discard_o = 1'b1;
                    state_d   = CFG_LOCKED;
                end
            end
            default: state_d = CFG_LOCKED;
        endcase
    end

    assign state_o = state_q;

    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_LOCKED && cmd_wr && wdata == key_i) |=> (state_o == CFG_STAGING));
    p_apply_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> (state_o == CFG_LOCKED));
    p_single_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(apply_o && discard_o));

endmodule

// File: rtl/cfg_bank_regs.sv
module cfg_bank_regs
    import cfg_bank_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned NODE_MIN    = 1,
    parameter int unsigned NODE_MAX    = 247,
    parameter int unsigned NODE_RESET  = 255,
    parameter int unsigned BAUD_COUNT  = 5,
    parameter int unsigned BAUD_RESET  = 1,
    parameter int unsigned TMO_RESET   = 60,
    parameter int unsigned KEY_RESET   = 16'hDEFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              stage_en_i,
    input  logic              apply_i,
    input  logic              discard_i,
    input  cfg_state_e        state_i,
    output cfg_rec_t          live_o,
    output logic [15:0]       rdata
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(REG_CMD);
    localparam logic [ADDR_W-1:0] A_LINK   = ADDR_W'(REG_LINK);
    localparam logic [ADDR_W-1:0] A_TMO    = ADDR_W'(REG_TMO);
    localparam logic [ADDR_W-1:0] A_PW     = ADDR_W'(REG_PW);

    localparam cfg_rec_t REC_RESET = '{
        pw:   KEY_RESET[15:0],
        tmo:  TMO_RESET[15:0],
        baud: BAUD_RESET[7:0],
        node: NODE_RESET[7:0]
    };

    cfg_rec_t shadow_q, live_q;
    logic [7:0] node_next, baud_next;
    logic       key_ok;

    cfg_byte_gate #(.LO(NODE_MIN), .HI(NODE_MAX)) u_node_gate (
        .cur_i (shadow_q.node),
        .req_i (wdata[7:0]),
        .nxt_o (node_next)
    );

    cfg_byte_gate #(.LO(1), .HI(BAUD_COUNT)) u_baud_gate (
        .cur_i (shadow_q.baud),
        .req_i (wdata[15:8]),
        .nxt_o (baud_next)
    );

    assign key_ok = (wdata != CODE_APPLY) && (wdata != CODE_DISCARD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= REC_RESET;
            live_q   <= REC_RESET;
        end else begin
            if (apply_i) live_q <= shadow_q;
            if (discard_i) begin
                shadow_q <= live_q;
            end else if (stage_en_i && wr_en) begin
                if (addr == A_LINK) begin
                    shadow_q.node <= node_next;
                    shadow_q.baud <= baud_next;
                end else if (addr == A_TMO) begin
                    shadow_q.tmo <= wdata;
                end else if (addr == A_PW && key_ok) begin
                    shadow_q.pw <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = 16'h0000;
        if (addr == A_STATUS)    rdata = 16'h0000;
        else if (addr == A_CMD)  rdata = {15'd0, state_i};
        else if (addr == A_LINK) rdata = {shadow_q.baud, shadow_q.node};
        else if (addr == A_TMO)  rdata = shadow_q.tmo;
        else if (addr == A_PW)   rdata = shadow_q.pw;
    end

    assign live_o = live_q;

    p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == CFG_LOCKED) |=> $stable(shadow_q));
    p_node_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q.node == NODE_RESET[7:0]) ||
        (live_q.node >= NODE_MIN[7:0] && live_q.node <= NODE_MAX[7:0]));
    p_baud_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q.baud >= 8'd1) && (live_q.baud <= BAUD_COUNT[7:0]));
    p_live_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> $stable(live_q));
    p_key_not_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_q.pw != CODE_APPLY) && (shadow_q.pw != CODE_DISCARD));

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter int unsigned ADDR_W     = 3,
    parameter int unsigned NODE_MIN   = 1,
    parameter int unsigned NODE_MAX   = 247,
    parameter int unsigned NODE_RESET = 255,
    parameter int unsigned BAUD_COUNT = 5,
    parameter int unsigned BAUD_RESET = 1,
    parameter int unsigned TMO_RESET  = 60,
    parameter int unsigned KEY_RESET  = 16'hDEFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [7:0]        node_id,
    output logic [7:0]        baud_idx,
    output logic [15:0]       wdt_timeout,
    output logic              cfg_state
);
    cfg_state_e st;
    cfg_rec_t   live;
    logic       stage_en, apply, discard;

    cfg_bank_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .key_i      (live.pw),
        .state_o    (st),
        .stage_en_o (stage_en),
        .apply_o    (apply),
        .discard_o  (discard)
    );

    cfg_bank_regs #(
        .ADDR_W     (ADDR_W),
        .NODE_MIN   (NODE_MIN),
        .NODE_MAX   (NODE_MAX),
        .NODE_RESET (NODE_RESET),
        .BAUD_COUNT (BAUD_COUNT),
        .BAUD_RESET (BAUD_RESET),
        .TMO_RESET  (TMO_RESET),
        .KEY_RESET  (KEY_RESET)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .stage_en_i (stage_en),
        .apply_i    (apply),
        .discard_i  (discard),
        .state_i    (st),
        .live_o     (live),
        .rdata      (rdata)
    );

    assign node_id     = live.node;
    assign baud_idx    = live.baud;
    assign wdt_timeout = live.tmo;
    assign cfg_state   = st;

    p_discard_locks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state && wr_en && addr == 3'(REG_CMD) && wdata == CODE_DISCARD) |=> !cfg_state);

endmodule

// File: tb/test_cfg_bank.sv
module test_cfg_bank;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    typedef struct packed {
        logic [2:0]  waddr;
        logic [15:0] wdata;
        logic [2:0]  raddr;
        logic [15:0] rexp;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 16'h0101, 3'd2, 16'h01FF, "R3"},
        '{3'd3, 16'h0005, 3'd3, 16'h003C, "R3"},
        '{3'd1, 16'h1234, 3'd1, 16'h0000, "R2"},
        '{3'd1, 16'hDEFA, 3'd1, 16'h0001, "R2"},
        '{3'd2, 16'h0000, 3'd2, 16'h01FF, "R6"},
        '{3'd2, 16'h0010, 3'd2, 16'h0110, "R6"},
        '{3'd2, 16'h0300, 3'd2, 16'h0310, "R6"},
        '{3'd2, 16'h00F8, 3'd2, 16'h0310, "R4"},
        '{3'd2, 16'h00F7, 3'd2, 16'h03F7, "R4"},
        '{3'd2, 16'h0601, 3'd2, 16'h0301, "R5"},
        '{3'd2, 16'h0505, 3'd2, 16'h0505, "R5"},
        '{3'd3, 16'h1234, 3'd3, 16'h1234, "R9"},
        '{3'd4, 16'h5FAF, 3'd4, 16'hDEFA, "R9"},
        '{3'd4, 16'h0000, 3'd4, 16'hDEFA, "R9"},
        '{3'd4, 16'hBEEF, 3'd4, 16'hBEEF, "R9"},
        '{3'd1, 16'h7777, 3'd1, 16'h0001, "R10"}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic [7:0]  node_id, baud_idx;
    logic [15:0] wdt_timeout;
    logic        cfg_state;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_bank i_cfg_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .node_id     (node_id),
        .baud_idx    (baud_idx),
        .wdt_timeout (wdt_timeout),
        .cfg_state   (cfg_state)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check_outs(input string tag, input logic [7:0] n, input logic [7:0] b,
                              input logic [15:0] t, input logic s);
        #1;
        check(tag, {8'd0, node_id}, {8'd0, n});
        check(tag, {8'd0, baud_idx}, {8'd0, b});
        check(tag, wdt_timeout, t);
        check(tag, {15'd0, cfg_state}, {15'd0, s});
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_outs("R1", 8'hFF, 8'd1, 16'd60, 1'b0);
        read_reg(3'd2, rd); check("R1", rd, 16'h01FF);
        read_reg(3'd3, rd); check("R1", rd, 16'h003C);
        read_reg(3'd4, rd); check("R1", rd, 16'hDEFA);
        read_reg(3'd1, rd); check("R10", rd, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            write_reg(VECS[i].waddr, VECS[i].wdata);
            read_reg(VECS[i].raddr, rd);
            check(string'(VECS[i].tag), rd, VECS[i].rexp);
        end

        // R7: outputs untouched while staging
        check_outs("R7", 8'hFF, 8'd1, 16'd60, 1'b1);
        write_reg(3'd1, 16'h5FAF);
        check_outs("R7", 8'h05, 8'd5, 16'h1234, 1'b0);

        // R9: old password no longer opens the bank, new one does
        write_reg(3'd1, 16'hDEFA);
        read_reg(3'd1, rd); check("R9", rd, 16'h0000);
        write_reg(3'd2, 16'h0202);
        read_reg(3'd2, rd); check("R3", rd, 16'h0505);
        write_reg(3'd1, 16'hBEEF);
        read_reg(3'd1, rd); check("R9", rd, 16'h0001);

        // R8: cancel discards staged edits
        write_reg(3'd2, 16'h0220);
        write_reg(3'd3, 16'h0099);
        read_reg(3'd2, rd); check("R8", rd, 16'h0220);
        write_reg(3'd1, 16'h0000);
        read_reg(3'd2, rd); check("R8", rd, 16'h0505);
        read_reg(3'd3, rd); check("R8", rd, 16'h1234);
        check_outs("R8", 8'h05, 8'd5, 16'h1234, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule